// File: doc/BRIEF.md
# Address Decoder and Bank-Switching MMU for an 8-bit CPU Bus

This block sits beside an 8-bit processor that has separate memory-request and I/O-request strobes. It looks at the request and direction strobes together with a few upper address lines, and pulls exactly one active-low chip select for the device being addressed. The 64 KB memory space splits into eight 8 KB blocks: the lower six reach a 128 KB SRAM, the seventh reaches the sound device and the eighth reaches the display device. The I/O space splits into four 64-byte blocks: the control register, the sound device's ports, the display device's ports and a spare expansion block.

A small control register, readable by the CPU, holds a bank number, a page-size number and an LED bit; on read-back the top bit shows the live push-button level. The MMU part makes the upper three SRAM address bits. Below a boundary set by the page-size field, SRAM is seen unchanged; at and above it, the 16 KB page number is XOR-ed with the bank number, so any 16 KB piece of the 128 KB part can be brought into the banked window. A device reset output follows the CPU reset unless a boot controller claims ownership, so that the boot controller can load the peripherals and the control register while the CPU is still held in reset.

The block has no data stream; all pins are plain control and status signals.

Top module: `bus_decode_mmu`

## Requirements
- R1: No chip select is driven low unless exactly one of `mreq_n`/`iorq_n` is low and exactly one of `rd_n`/`wr_n` is low; a control-register write attempted under any other strobe combination leaves the register unchanged.
- R2: With a qualified memory access, `a_hi` (address bits 15..13) values 0 to 5 drive `sram_cs_n` low, value 6 drives `aud_mem_cs_n` low and value 7 drives `vid_mem_cs_n` low.
- R3: With a qualified I/O access, `a_io` (address bits 7..6) value 0 selects the control register (`ctl_rd_cs_n` low on a read, `ctl_wr_cs_n` low on a write), 1 drives `aud_io_cs_n`, 2 drives `vid_io_cs_n` and 3 drives `exp_io_cs_n` low.
- R4: At most one chip select output is low at any time.
- R5: In the unbanked region `sram_a` equals {0, address bit 15, address bit 14}, the 16 KB page number unchanged.
- R6: In the banked region `sram_a` equals the 16 KB page number XOR the bank field.
- R7: The banked region starts at page-size × 16 KB with the start clamped to 0xC000 (page 3); page-size 0 makes every SRAM page banked.
- R8: Bank and page-size values never change the sound, display or I/O chip selects.
- R9: `dev_rst_n` is low exactly when `cpu_rst_n` is low and `boot_own` is low.
- R10: The control register is cleared by the device reset only; with `boot_own` high it keeps and accepts values while `cpu_rst_n` is low.
- R11: On each clock edge at which the control-register write select is active, the register takes `ctl_wdata`: bits 2..0 are the bank, bits 5..3 the page size, bit 6 the LED. `ctl_rdata` is {`btn`, bits 6..0 of the register} and `led` follows bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the control register |
| cpu_rst_n | input | 1 | CPU reset, active low |
| boot_own | input | 1 | Boot controller claims the peripherals, active high |
| mreq_n | input | 1 | Memory request strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a_hi | input | 3 | CPU address bits 15..13 |
| a_io | input | 2 | CPU address bits 7..6 |
| ctl_wdata | input | 7 | Data bus bits 6..0 written into the control register |
| btn | input | 1 | Live push-button level |
| ctl_rdata | output | 8 | Control register read-back value |
| led | output | 1 | LED bit of the control register |
| sram_a | output | 3 | SRAM address bits 16..14 |
| sram_cs_n | output | 1 | SRAM select, active low |
| aud_mem_cs_n | output | 1 | Sound device memory select, active low |
| aud_io_cs_n | output | 1 | Sound device I/O select, active low |
| vid_mem_cs_n | output | 1 | Display device memory select, active low |
| vid_io_cs_n | output | 1 | Display device I/O select, active low |
| ctl_rd_cs_n | output | 1 | Control register read select, active low |
| ctl_wr_cs_n | output | 1 | Control register write select, active low |
| exp_io_cs_n | output | 1 | Expansion I/O select, active low |
| dev_rst_n | output | 1 | Device reset, active low |

## Verification
On every cycle the assertions check that no more than one select is low, that all selects stay high under an illegal or idle strobe combination, that the SRAM select only appears for the six low memory blocks, and that the control register loads exactly when written and otherwise holds. The XOR remapping at each page-size and bank value, the clamp of the boundary at page 3, the register surviving a CPU reset while the boot controller owns the devices, and the independence of the sound and display selects from the MMU fields can only be shown by the bench's sweeps and reset sequences against its reference model.

// File: rtl/bdm_pkg.sv
package bdm_pkg;

  localparam int unsigned FIELD_W = 3;

  // Control register contents (bit 7 of the bus view is the live button)
  typedef struct packed {
    logic               led;
    logic [FIELD_W-1:0] psize;
    logic [FIELD_W-1:0] bank;
  } ctl_t;

  // Qualified bus access
  typedef struct packed {
    logic mem;
    logic io;
    logic rd;
    logic wr;
  } acc_t;

endpackage

// File: rtl/bdm_strobe_qual.sv
module bdm_strobe_qual
  import bdm_pkg::*;
(
  input  logic mreq_n,
  input  logic iorq_n,
  input  logic rd_n,
  input  logic wr_n,
  output acc_t acc
);

  logic one_req;
  logic one_dir;
  logic legal;

  // Exactly one space and exactly one direction, otherwise nothing is seen
  assign one_req = mreq_n ^ iorq_n;
  assign one_dir = rd_n ^ wr_n;
  assign legal   = one_req & one_dir;

  assign acc.mem = legal & ~mreq_n;
  assign acc.io  = legal & ~iorq_n;
  assign acc.rd  = legal & ~rd_n;
  assign acc.wr  = legal & ~wr_n;

endmodule

// File: rtl/bdm_select.sv
module bdm_select
  import bdm_pkg::*;
#(
  parameter int unsigned MEM_BLK_W = 3,
  parameter int unsigned IO_BLK_W  = 2,
  parameter int unsigned AUD_BLK   = 6,
  parameter int unsigned VID_BLK   = 7,
  parameter int unsigned CTL_IO    = 0,
  parameter int unsigned AUD_IO    = 1,
  parameter int unsigned VID_IO    = 2,
  parameter int unsigned EXP_IO    = 3
) (
  input  acc_t                 acc,
  input  logic [MEM_BLK_W-1:0] a_hi,
  input  logic [IO_BLK_W-1:0]  a_io,
  output logic                 sram_cs_n,
  output logic                 aud_mem_cs_n,
  output logic                 vid_mem_cs_n,
  output logic                 ctl_rd_cs_n,
  output logic                 ctl_wr_cs_n,
  output logic                 aud_io_cs_n,
  output logic                 vid_io_cs_n,
  output logic                 exp_io_cs_n
);

  localparam int unsigned MEM_BLKS = 1 << MEM_BLK_W;
  localparam int unsigned IO_BLKS  = 1 << IO_BLK_W;

  logic [MEM_BLKS-1:0] mem_hit;
  logic [IO_BLKS-1:0]  io_hit;

  // One hit line per address block
  for (genvar b = 0; b < MEM_BLKS; b++) begin : g_mem
    assign mem_hit[b] = acc.mem && (a_hi == MEM_BLK_W'(b));
  end

  for (genvar b = 0; b < IO_BLKS; b++) begin : g_io
    assign io_hit[b] = acc.io && (a_io == IO_BLK_W'(b));
  end

  // SRAM owns every block below the sound device's block
  assign sram_cs_n    = ~(|mem_hit[AUD_BLK-1:0]);
  assign aud_mem_cs_n = ~mem_hit[AUD_BLK];
  assign vid_mem_cs_n = ~mem_hit[VID_BLK];

  assign ctl_rd_cs_n  = ~(io_hit[CTL_IO] & acc.rd);
  assign ctl_wr_cs_n  = ~(io_hit[CTL_IO] & acc.wr);
  assign aud_io_cs_n  = ~io_hit[AUD_IO];
  assign vid_io_cs_n  = ~io_hit[VID_IO];
  assign exp_io_cs_n  = ~io_hit[EXP_IO];

endmodule

// File: rtl/bdm_mmu.sv
module bdm_mmu
  import bdm_pkg::*;
#(
  parameter int unsigned PAGE_W     = 2,
  parameter int unsigned SRAM_HI_W  = 3,
  parameter int unsigned SRAM_PAGES = 3
) (
  input  logic [PAGE_W-1:0]    page,
  input  logic [FIELD_W-1:0]   bank,
  input  logic [FIELD_W-1:0]   psize,
  output logic [SRAM_HI_W-1:0] sram_a
);

  localparam logic [FIELD_W-1:0] LIMIT = FIELD_W'(SRAM_PAGES);

  logic [FIELD_W-1:0]   edge_pg;
  logic                 banked;
  logic [SRAM_HI_W-1:0] plain;

  // Boundary page, clamped to the top of the SRAM window
  assign edge_pg = (psize > LIMIT) ? LIMIT : psize;
  assign banked  = FIELD_W'(page) >= edge_pg;
  assign plain   = SRAM_HI_W'(page);
  assign sram_a  = banked ? (plain ^ SRAM_HI_W'(bank)) : plain;

endmodule

// File: rtl/bdm_ctl_reg.sv
module bdm_ctl_reg
  import bdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic [$bits(ctl_t)-1:0] wdata,
  input  logic               btn,
  output ctl_t               q,
  output logic [$bits(ctl_t):0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (wr_sel) q <= ctl_t'(wdata);
  end

  assign rdata = {btn, q};

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (q == ctl_t'($past(wdata)))); // R11

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(q)); // R1

endmodule

// File: rtl/bus_decode_mmu.sv
module bus_decode_mmu
  import bdm_pkg::*;
#(
  parameter int unsigned MEM_BLK_W  = 3,
  parameter int unsigned IO_BLK_W   = 2,
  parameter int unsigned SRAM_HI_W  = 3,
  parameter int unsigned AUD_BLK    = 6,
  parameter int unsigned VID_BLK    = 7
) (
  input  logic                   clk,
  input  logic                   cpu_rst_n,
  input  logic                   boot_own,
  input  logic                   mreq_n,
  input  logic                   iorq_n,
  input  logic                   rd_n,
  input  logic                   wr_n,
  input  logic [MEM_BLK_W-1:0]   a_hi,
  input  logic [IO_BLK_W-1:0]    a_io,
  input  logic [6:0]             ctl_wdata,
  input  logic                   btn,
  output logic [7:0]             ctl_rdata,
  output logic                   led,
  output logic [SRAM_HI_W-1:0]   sram_a,
  output logic                   sram_cs_n,
  output logic                   aud_mem_cs_n,
  output logic                   aud_io_cs_n,
  output logic                   vid_mem_cs_n,
  output logic                   vid_io_cs_n,
  output logic                   ctl_rd_cs_n,
  output logic                   ctl_wr_cs_n,
  output logic                   exp_io_cs_n,
  output logic                   dev_rst_n
);

  // 16 KB page number is the upper part of the 8 KB block number
  localparam int unsigned PAGE_W     = MEM_BLK_W - 1;
  localparam int unsigned SRAM_PAGES = AUD_BLK / 2;

  acc_t acc;
  ctl_t ctl_q;

  // Peripherals leave reset early when the boot controller owns them
  assign dev_rst_n = cpu_rst_n | boot_own;

  bdm_strobe_qual u_qual (
    .mreq_n (mreq_n),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .acc    (acc)
  );

  bdm_select #(
    .MEM_BLK_W (MEM_BLK_W),
    .IO_BLK_W  (IO_BLK_W),
    .AUD_BLK   (AUD_BLK),
    .VID_BLK   (VID_BLK)
  ) u_sel (
    .acc          (acc),
    .a_hi         (a_hi),
    .a_io         (a_io),
    .sram_cs_n    (sram_cs_n),
    .aud_mem_cs_n (aud_mem_cs_n),
    .vid_mem_cs_n (vid_mem_cs_n),
    .ctl_rd_cs_n  (ctl_rd_cs_n),
    .ctl_wr_cs_n  (ctl_wr_cs_n),
    .aud_io_cs_n  (aud_io_cs_n),
    .vid_io_cs_n  (vid_io_cs_n),
    .exp_io_cs_n  (exp_io_cs_n)
  );

  bdm_ctl_reg u_ctl (
    .clk    (clk),
    .rst_n  (dev_rst_n),
    .wr_sel (~ctl_wr_cs_n),
    .wdata  (ctl_wdata),
    .btn    (btn),
    .q      (ctl_q),
    .rdata  (ctl_rdata)
  );

  bdm_mmu #(
    .PAGE_W     (PAGE_W),
    .SRAM_HI_W  (SRAM_HI_W),
    .SRAM_PAGES (SRAM_PAGES)
  ) u_mmu (
    .page   (a_hi[MEM_BLK_W-1 -: PAGE_W]),
    .bank   (ctl_q.bank),
    .psize  (ctl_q.psize),
    .sram_a (sram_a)
  );

  assign led = ctl_q.led;

  logic [7:0] cs_n_vec;
  assign cs_n_vec = {sram_cs_n, aud_mem_cs_n, aud_io_cs_n, vid_mem_cs_n,
                     vid_io_cs_n, ctl_rd_cs_n, ctl_wr_cs_n, exp_io_cs_n};

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!dev_rst_n)
    $countones(~cs_n_vec) <= 1); // R4

  AST_IDLE_NO_SELECT: assert property (@(posedge clk) disable iff (!dev_rst_n)
    ((mreq_n == iorq_n) || (rd_n == wr_n)) |-> (&cs_n_vec)); // R1

  AST_SRAM_RANGE: assert property (@(posedge clk) disable iff (!dev_rst_n)
    !sram_cs_n |-> (!mreq_n && (a_hi < MEM_BLK_W'(AUD_BLK)))); // R2

endmodule

// File: tb/sim_bus_decode_mmu.sv
`timescale 1ns/1ps
module sim_bus_decode_mmu;

  logic       clk = 1'b0;
  logic       cpu_rst_n, boot_own, mreq_n, iorq_n, rd_n, wr_n, btn;
  logic [2:0] a_hi;
  logic [1:0] a_io;
  logic [6:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       led;
  logic [2:0] sram_a;
  logic       sram_cs_n, aud_mem_cs_n, aud_io_cs_n, vid_mem_cs_n, vid_io_cs_n;
  logic       ctl_rd_cs_n, ctl_wr_cs_n, exp_io_cs_n, dev_rst_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int model = 0;   // reference copy of the seven stored bits

  always #2.5 clk = ~clk;

  bus_decode_mmu u0 (.*);

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Apply one vector at the falling edge and compare against the model
  task automatic vec(input bit mq, input bit iq, input bit r, input bit w,
                     input int hi, input int io, input int wd, input bit b,
                     input bit crst, input bit own);
    bit legal, mem, iox, rdx, wrx, drst;
    int pg, lim, bk, ps, exp_sa, lows;
    string mt;
    @(negedge clk);
    mreq_n = mq; iorq_n = iq; rd_n = r; wr_n = w;
    a_hi = 3'(hi); a_io = 2'(io); ctl_wdata = 7'(wd); btn = b;
    cpu_rst_n = crst; boot_own = own;
    #1;
    drst  = !crst && !own;
    if (drst) model = 0;
    legal = (mq != iq) && (r != w);
    mem = legal && !mq; iox = legal && !iq;
    rdx = legal && !r;  wrx = legal && !w;
    mt = legal ? "R2" : "R1";
    chk("R9", "dev_rst_n", 8'(dev_rst_n), 8'(!drst));
    chk(mt, "sram_cs_n", 8'(sram_cs_n), 8'(!(mem && hi < 6)));
    chk(mt, "aud_mem_cs_n", 8'(aud_mem_cs_n), 8'(!(mem && hi == 6)));
    chk("R8", "vid_mem_cs_n", 8'(vid_mem_cs_n), 8'(!(mem && hi == 7)));
    mt = legal ? "R3" : "R1";
    chk(mt, "ctl_rd_cs_n", 8'(ctl_rd_cs_n), 8'(!(iox && io == 0 && rdx)));
    chk(mt, "ctl_wr_cs_n", 8'(ctl_wr_cs_n), 8'(!(iox && io == 0 && wrx)));
    chk(mt, "aud_io_cs_n", 8'(aud_io_cs_n), 8'(!(iox && io == 1)));
    chk("R8", "vid_io_cs_n", 8'(vid_io_cs_n), 8'(!(iox && io == 2)));
    chk(mt, "exp_io_cs_n", 8'(exp_io_cs_n), 8'(!(iox && io == 3)));
    lows = 0;
    lows += !sram_cs_n; lows += !aud_mem_cs_n; lows += !aud_io_cs_n;
    lows += !vid_mem_cs_n; lows += !vid_io_cs_n; lows += !ctl_rd_cs_n;
    lows += !ctl_wr_cs_n; lows += !exp_io_cs_n;
    chk("R4", "select_count_le1", 8'(lows <= 1), 8'd1);
    bk = model & 7; ps = (model >> 3) & 7;
    pg = hi >> 1;
    lim = (ps > 3) ? 3 : ps;
    exp_sa = (pg >= lim) ? (pg ^ bk) : pg;
    if (pg == lim || lim == 0) mt = "R7";
    else mt = (pg >= lim) ? "R6" : "R5";
    chk(mt, "sram_a", 8'(sram_a), 8'(exp_sa));
    chk(drst ? "R10" : "R11", "ctl_rdata", ctl_rdata, 8'({b, 7'(model)}));
    chk("R11", "led", 8'(led), 8'((model >> 6) & 1));
    // Register takes the data at the coming rising edge
    if (!drst && iox && io == 0 && wrx) model = wd & 8'h7f;
  endtask

  task automatic ctl_wr(input int wd, input bit crst, input bit own);
    vec(1, 0, 1, 0, 0, 0, wd, 0, crst, own);
  endtask

  initial begin
    // R9 R10: reset state with both resets asserted
    for (int i = 0; i < 3; i++) vec(1, 1, 1, 1, 0, 0, 0, i[0], 0, 0);
    vec(1, 0, 1, 0, 0, 0, 7'h55, 0, 0, 0);   // write while device reset: no effect
    vec(1, 0, 0, 1, 0, 0, 0, 1, 0, 0);
    // R10: boot controller owns devices while the CPU stays in reset
    ctl_wr(7'h5a, 0, 1);
    vec(1, 0, 0, 1, 0, 0, 0, 1, 0, 1);
    vec(0, 1, 0, 1, 5, 0, 0, 0, 0, 1);
    vec(1, 0, 0, 1, 0, 0, 0, 0, 1, 0);       // CPU released: value kept
    vec(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);       // full reset clears
    vec(1, 0, 0, 1, 0, 0, 0, 1, 1, 0);
    // R2 R5 R6 R7 R8: sweep page size, bank and every memory block
    for (int ps = 0; ps < 8; ps++) begin
      for (int k = 0; k < 3; k++) begin
        int bk = (k == 0) ? 0 : ((k == 1) ? 5 : 7);
        ctl_wr((k << 6) | (ps << 3) | bk, 1, 0);
        for (int hi = 0; hi < 8; hi++) begin
          vec(0, 1, 0, 1, hi, hi & 3, 0, hi[0], 1, 0);
          vec(0, 1, 1, 0, hi, 0, 0, 0, 1, 0);
        end
      end
    end
    // R3: every I/O block in both directions
    for (int io = 0; io < 4; io++) begin
      vec(1, 0, 0, 1, 7, io, 0, 1, 1, 0);
      vec(1, 0, 1, 0, 7, io, 7'h40 | io, 0, 1, 0);
      vec(1, 0, 0, 1, 0, 0, 0, 0, 1, 0);
    end
    // R1: illegal strobe mixes must not write or select
    ctl_wr(7'h2b, 1, 0);
    vec(0, 0, 1, 0, 0, 0, 7'h11, 0, 1, 0);
    vec(1, 0, 0, 0, 0, 0, 7'h12, 0, 1, 0);
    vec(0, 0, 0, 0, 0, 0, 7'h13, 0, 1, 0);
    vec(1, 1, 1, 0, 0, 0, 7'h14, 0, 1, 0);
    vec(1, 0, 1, 1, 0, 0, 7'h15, 0, 1, 0);
    vec(1, 0, 0, 1, 0, 0, 0, 1, 1, 0);
    // Mixed pseudo-random traffic, mostly out of reset
    for (int i = 0; i < 3000; i++) begin
      int rv = int'($urandom);
      int sel = rv & 15;
      bit cr = (sel != 0);
      vec(rv[4], rv[5], rv[6], rv[7], (rv >> 8) & 7, (rv >> 11) & 3,
          (rv >> 13) & 8'h7f, rv[20], cr, rv[21]);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule